// File: doc/BRIEF.md
# Range Lookup Table Builder

This block turns a sorted list of prefix range endpoints into the rows of a range-search lookup table. Each endpoint carries its key (the prefix padded with zeros for its low point, or with ones for its high point), a flag saying whether it is the low or the high point, and the identifier of its prefix. The endpoints arrive in ascending key order on a valid/ready stream, and the last one of a list is flagged. One linear pass over that list yields, for every distinct key, two results. The equal result is the prefix an address exactly equal to the key resolves to. The greater result is the prefix for any address strictly above the key and below the next row.

A stack of open prefixes drives the pass. A low point opens its prefix by pushing it, and the matching high point closes it by popping it. The top of the stack after a key is handled is that row's greater result. Endpoints that share a key are merged into one row. The block never patches the table: every change is applied by feeding the whole sorted list again, so any number of route changes may be folded into one rebuild. Faults in the list raise a sticky error flag for the build in which they occur.

Top module: `rtb_table_builder`

## Requirements
- R1: After reset, out_valid and build_err are 0 and in_ready is 1.
- R2: A row opened by a low point (in_high = 0) has its equal result set to that endpoint's identifier, and its prefix is pushed. If nothing else shares the key, the greater result is that identifier as well.
- R3: A high point (in_high = 1) whose identifier matches the top of the stack pops it. Its row's equal result is that identifier, and its greater result is the prefix below it on the stack.
- R4: When the stack is empty after a key is handled, that row's greater result is the no-match code, all ones in ID_W bits (identifier values must therefore differ from all ones).
- R5: All endpoints with the same key form one row. At a shared key, lows must come first, shortest prefix first, then highs, longest prefix first. The equal result is the last identifier pushed at that key, or the first one popped if no low shares the key. The greater result is the stack top after all of them.
- R6: A row is written (out_valid high for one cycle) at the clock edge that accepts the next endpoint with a different key. The final row of a list is written one cycle after its in_last endpoint is accepted, with out_last = 1. Within a build, out_addr counts 0, 1, 2, and so on.
- R7: in_ready is low for exactly the one cycle after an in_last endpoint is accepted. The next endpoint starts a new build with an empty stack and out_addr restarting at 0.
- R8: A low point arriving while the stack holds KEY_W+1 prefixes is not pushed and sets build_err.
- R9: A high point whose identifier is not on top of the stack (or arrives on an empty stack) pops nothing and sets build_err.
- R10: A key lower than the key of the previous endpoint, or a low point after a high point at the same key, sets build_err.
- R11: If the stack is not empty once the in_last endpoint has been handled, build_err is set.
- R12: build_err stays set through the rest of its build and while idle afterwards. It is cleared when the first endpoint of the next build is accepted, unless that endpoint is itself faulty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Endpoint offered |
| in_ready | output | 1 | Endpoint can be accepted this cycle |
| in_key | input | KEY_W | Endpoint key value |
| in_high | input | 1 | 1 = high point, 0 = low point |
| in_id | input | ID_W | Prefix identifier |
| in_last | input | 1 | Final endpoint of the sorted list |
| out_valid | output | 1 | Table row write strobe |
| out_addr | output | AW | Row index within the current build |
| out_key | output | KEY_W | Row key |
| out_eq | output | ID_W | Result when the address equals the key |
| out_gt | output | ID_W | Result when the address lies above the key |
| out_last | output | 1 | Row is the final one of the build |
| build_err | output | 1 | Sticky fault flag for the current build |

## Verification
The bench is driven with three kinds of valid list. The first is a chain of strictly nested prefixes, where each row's greater result must step down one level of nesting. The second is a set of disjoint prefixes, whose gaps must fall to the no-match code. The third is a list dense with shared keys: coincident lows, a full-length prefix sitting inside a shorter one, and a key where only highs meet. Together these separate correct innermost selection from first-seen or last-seen selection for the equal and greater results. Faulty lists (a wrong closing identifier, a descending key, a low after a high at one key, an unclosed prefix, a nesting deeper than the stack) are each followed by a clean build. This shows that each fault is flagged and that the flag clears only when the next build begins.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

    typedef enum logic {
        EP_LOW  = 1'b0,
        EP_HIGH = 1'b1
    } ep_kind_e;

    typedef struct packed {
        logic has_push;
        logic has_pop;
    } grp_flags_t;

    typedef struct packed {
        logic ovf;
        logic mismatch;
        logic order;
        logic unclosed;
    } fault_t;

    function automatic logic any_fault(input fault_t f);
        return f.ovf | f.mismatch | f.order | f.unclosed;
    endfunction

endpackage

// File: rtl/rtb_stack.sv
module rtb_stack #(
    parameter int DEPTH = 17,
    parameter int IDW = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           push,
    input  logic           pop,
    input  logic [IDW-1:0] push_id,
    output logic [IDW-1:0] top_id,
    output logic           top_vld,
    output logic [IDW-1:0] below_id,
    output logic           below_vld,
    output logic           full,
    output logic [CW-1:0]  count
);

    logic [IDW-1:0] mem [DEPTH];
    logic [CW-1:0]  top_idx;
    logic [CW-1:0]  below_idx;

    assign full      = (count == CW'(DEPTH));
    assign top_vld   = (count != '0);
    assign below_vld = (count > CW'(1));
    assign top_idx   = count - CW'(1);
    assign below_idx = count - CW'(2);
    assign top_id    = top_vld ? mem[top_idx] : '0;
    assign below_id  = below_vld ? mem[below_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CW'(1);
        end else if (pop && top_vld) begin
            count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            mem[count] <= push_id;
        end
    end

    // R8: depth bound of the nesting stack
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9: a pop request only reaches the stack when something is stacked
    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
        pop |-> top_vld);

endmodule

// File: rtl/rtb_group.sv
module rtb_group
    import rtb_pkg::*;
#(
    parameter int KW = 16,
    parameter int IDW = 8,
    parameter int AW = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           acc,
    input  logic           flush,
    input  logic           same_grp,
    input  ep_kind_e       kind,
    input  logic [KW-1:0]  key,
    input  logic [IDW-1:0] id,
    input  logic [IDW-1:0] gt_after,
    output logic           pend_vld,
    output logic [KW-1:0]  pend_key,
    output logic [IDW-1:0] pend_gt,
    output grp_flags_t     pend_flags,
    output logic           out_valid,
    output logic [AW-1:0]  out_addr,
    output logic [KW-1:0]  out_key,
    output logic [IDW-1:0] out_eq,
    output logic [IDW-1:0] out_gt,
    output logic           out_last
);

    logic [IDW-1:0] pend_eq;
    logic [AW-1:0]  next_addr;
    logic           emit;

    assign emit = flush || (acc && !same_grp && pend_vld);

    // row output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_addr  <= '0;
            out_key   <= '0;
            out_eq    <= '0;
            out_gt    <= '0;
            next_addr <= '0;
        end else begin
            out_valid <= emit && pend_vld;
            out_last  <= flush && pend_vld;
            if (emit) begin
                out_addr <= next_addr;
                out_key  <= pend_key;
                out_eq   <= pend_eq;
                out_gt   <= pend_gt;
                next_addr <= flush ? '0 : next_addr + AW'(1);
            end
        end
    end

    // pending row being assembled for the current key
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld   <= 1'b0;
            pend_key   <= '0;
            pend_eq    <= '0;
            pend_gt    <= '0;
            pend_flags <= '0;
        end else if (flush) begin
            pend_vld   <= 1'b0;
            pend_flags <= '0;
        end else if (acc) begin
            pend_gt <= gt_after;
            if (same_grp) begin
                if (kind == EP_LOW) begin
                    pend_flags.has_push <= 1'b1;
                    if (!pend_flags.has_pop) begin
                        pend_eq <= id;
                    end
                end else begin
                    pend_flags.has_pop <= 1'b1;
                end
            end else begin
                pend_vld            <= 1'b1;
                pend_key            <= key;
                pend_eq             <= id;
                pend_flags.has_push <= (kind == EP_LOW);
                pend_flags.has_pop  <= (kind == EP_HIGH);
            end
        end
    end

    // R6: rows of one build take consecutive addresses
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> (!out_valid || out_addr == $past(out_addr) + AW'(1)));

    // R6: the final row stands alone
    assert_last_alone_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |=> !out_valid);

endmodule

// File: rtl/rtb_table_builder.sv
module rtb_table_builder
    import rtb_pkg::*;
#(
    parameter int KEY_W = 16,
    parameter int ID_W = 8,
    parameter int MAX_ENTRIES = 1024,
    localparam int DEPTH = KEY_W + 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int AW = $clog2(MAX_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KEY_W-1:0] in_key,
    input  logic             in_high,
    input  logic [ID_W-1:0]  in_id,
    input  logic             in_last,
    output logic             out_valid,
    output logic [AW-1:0]    out_addr,
    output logic [KEY_W-1:0] out_key,
    output logic [ID_W-1:0]  out_eq,
    output logic [ID_W-1:0]  out_gt,
    output logic             out_last,
    output logic             build_err
);

    localparam logic [ID_W-1:0] NO_MATCH = '1;

    logic             flush_q;
    logic             in_build;
    logic             acc;
    ep_kind_e         kind;
    logic             is_low;
    logic             push;
    logic             pop;
    logic             same_grp;
    logic [ID_W-1:0]  gt_after;
    logic             end_nonempty;
    fault_t           fault;

    logic [ID_W-1:0]  stk_top;
    logic             stk_top_vld;
    logic [ID_W-1:0]  stk_below;
    logic             stk_below_vld;
    logic             stk_full;
    logic [CNT_W-1:0] stk_count;

    logic             pend_vld;
    logic [KEY_W-1:0] pend_key;
    logic [ID_W-1:0]  pend_gt;
    grp_flags_t       pend_flags;

    assign in_ready = !flush_q;
    assign acc      = in_valid && in_ready;
    assign kind     = ep_kind_e'(in_high);
    assign is_low   = (kind == EP_LOW);
    assign same_grp = pend_vld && (in_key == pend_key);
    assign push     = acc && is_low && !stk_full;
    assign pop      = acc && !is_low && stk_top_vld && (stk_top == in_id);

    always_comb begin
        if (is_low) begin
            gt_after = stk_full ? stk_top : in_id;
        end else if (pop) begin
            gt_after = stk_below_vld ? stk_below : NO_MATCH;
        end else begin
            gt_after = stk_top_vld ? stk_top : NO_MATCH;
        end
    end

    always_comb begin
        if (push) begin
            end_nonempty = 1'b1;
        end else if (pop) begin
            end_nonempty = (stk_count != CNT_W'(1));
        end else begin
            end_nonempty = (stk_count != '0);
        end
    end

    always_comb begin
        fault.ovf      = acc && is_low && stk_full;
        fault.mismatch = acc && !is_low && !pop;
        fault.order    = acc && pend_vld &&
                         ((in_key < pend_key) || (same_grp && is_low && pend_flags.has_pop));
        fault.unclosed = acc && in_last && end_nonempty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q   <= 1'b0;
            in_build  <= 1'b0;
            build_err <= 1'b0;
        end else begin
            flush_q <= acc && in_last;
            if (acc) begin
                in_build  <= !in_last;
                build_err <= (in_build && build_err) || any_fault(fault);
            end
        end
    end

    rtb_stack #(.DEPTH(DEPTH), .IDW(ID_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .clear     (flush_q),
        .push      (push),
        .pop       (pop),
        .push_id   (in_id),
        .top_id    (stk_top),
        .top_vld   (stk_top_vld),
        .below_id  (stk_below),
        .below_vld (stk_below_vld),
        .full      (stk_full),
        .count     (stk_count)
    );

    rtb_group #(.KW(KEY_W), .IDW(ID_W), .AW(AW)) u_group (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .flush      (flush_q),
        .same_grp   (same_grp),
        .kind       (kind),
        .key        (in_key),
        .id         (in_id),
        .gt_after   (gt_after),
        .pend_vld   (pend_vld),
        .pend_key   (pend_key),
        .pend_gt    (pend_gt),
        .pend_flags (pend_flags),
        .out_valid  (out_valid),
        .out_addr   (out_addr),
        .out_key    (out_key),
        .out_eq     (out_eq),
        .out_gt     (out_gt),
        .out_last   (out_last)
    );

    // R4: an empty stack leaves the pending row pointing at no-match
    assert_gt_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (pend_vld && !stk_top_vld) |-> (pend_gt == NO_MATCH));

    // R7: one stall cycle after the final endpoint
    assert_stall_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && in_last) |=> !in_ready);

    assert_stall_single_R7: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    // R5: rows of a clean build have strictly rising keys
    assert_keys_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last && !build_err) |=>
            (!out_valid || build_err || out_key > $past(out_key)));

    // R12: the fault flag holds while its build is open
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (build_err && in_build) |=> build_err);

endmodule

// File: tb/rtb_table_builder_bench.sv
module rtb_table_builder_bench;

    localparam logic [7:0] NM = 8'hFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_key = '0;
    logic        in_high = 1'b0;
    logic [7:0]  in_id = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [9:0]  out_addr;
    logic [15:0] out_key;
    logic [7:0]  out_eq;
    logic [7:0]  out_gt;
    logic        out_last;
    logic        build_err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int cap_n = 0;
    int acc_n = 0;
    int cap_key [32];
    int cap_eq [32];
    int cap_gt [32];
    int cap_addr [32];
    int cap_last [32];
    int cap_cyc [32];
    int acc_cyc [32];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rtb_table_builder u_rtb_table_builder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .in_high(in_high), .in_id(in_id), .in_last(in_last),
        .out_valid(out_valid), .out_addr(out_addr), .out_key(out_key),
        .out_eq(out_eq), .out_gt(out_gt), .out_last(out_last),
        .build_err(build_err)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && cap_n < 32) begin
            cap_key[cap_n]  = int'(out_key);
            cap_eq[cap_n]   = int'(out_eq);
            cap_gt[cap_n]   = int'(out_gt);
            cap_addr[cap_n] = int'(out_addr);
            cap_last[cap_n] = int'(out_last);
            cap_cyc[cap_n]  = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic new_build();
        cap_n = 0;
        acc_n = 0;
    endtask

    task automatic send(input logic [15:0] k, input logic hi, input logic [7:0] id,
                        input logic lst);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_key   = k;
        in_high  = hi;
        in_id    = id;
        in_last  = lst;
        @(negedge clk);
        acc_cyc[acc_n] = cyc;
        acc_n++;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic row(input int i, input int k, input int eq, input int gt,
                       input string req);
        chk(cap_key[i] == k, req, $sformatf("row %0d key", i), cap_key[i], k);
        chk(cap_eq[i] == eq, req, $sformatf("row %0d eq", i), cap_eq[i], eq);
        chk(cap_gt[i] == gt, req, $sformatf("row %0d gt", i), cap_gt[i], gt);
        chk(cap_addr[i] == i, "R6", $sformatf("row %0d addr", i), cap_addr[i], i);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        chk(build_err == 1'b0, "R1", "build_err", int'(build_err), 0);
        chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    endtask

    // nested chain: 1*, 101*, 10101* on 16-bit keys
    task automatic t_nested();
        new_build();
        send(16'h8000, 1'b0, 8'd1, 1'b0);
        send(16'hA000, 1'b0, 8'd2, 1'b0);
        send(16'hA800, 1'b0, 8'd3, 1'b0);
        send(16'hAFFF, 1'b1, 8'd3, 1'b0);
        send(16'hBFFF, 1'b1, 8'd2, 1'b0);
        send(16'hFFFF, 1'b1, 8'd1, 1'b1);
        chk(in_ready == 1'b0, "R7", "ready in stall cycle", int'(in_ready), 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R7", "ready after stall", int'(in_ready), 1);
        settle();
        chk(cap_n == 6, "R6", "row count", cap_n, 6);
        row(0, 16'h8000, 1, 1, "R2");
        row(1, 16'hA000, 2, 2, "R2");
        row(2, 16'hA800, 3, 3, "R2");
        row(3, 16'hAFFF, 3, 2, "R3");
        row(4, 16'hBFFF, 2, 1, "R3");
        row(5, 16'hFFFF, 1, NM, "R4");
        chk(cap_last[5] == 1, "R6", "out_last on final", cap_last[5], 1);
        chk(cap_last[4] == 0, "R6", "out_last before final", cap_last[4], 0);
        chk(cap_cyc[0] == acc_cyc[1], "R6", "first row timing", cap_cyc[0], acc_cyc[1]);
        chk(cap_cyc[5] == acc_cyc[5] + 1, "R6", "final row timing", cap_cyc[5], acc_cyc[5] + 1);
        chk(build_err == 1'b0, "R12", "no fault on clean list", int'(build_err), 0);
    endtask

    // shared keys: coincident lows, full-length prefixes, highs only
    task automatic t_merge();
        new_build();
        send(16'h0000, 1'b0, 8'd1, 1'b0);
        send(16'h0000, 1'b0, 8'd2, 1'b0);
        send(16'h1230, 1'b0, 8'd5, 1'b0);
        send(16'h1234, 1'b0, 8'd3, 1'b0);
        send(16'h1234, 1'b1, 8'd3, 1'b0);
        send(16'h123F, 1'b0, 8'd6, 1'b0);
        send(16'h123F, 1'b1, 8'd6, 1'b0);
        send(16'h123F, 1'b1, 8'd5, 1'b0);
        send(16'h3000, 1'b0, 8'd7, 1'b0);
        send(16'h3FFF, 1'b1, 8'd7, 1'b0);
        send(16'h3FFF, 1'b1, 8'd2, 1'b0);
        send(16'h7FFF, 1'b1, 8'd1, 1'b1);
        settle();
        chk(cap_n == 7, "R5", "merged row count", cap_n, 7);
        row(0, 16'h0000, 2, 2, "R5");
        row(1, 16'h1230, 5, 5, "R5");
        row(2, 16'h1234, 3, 5, "R5");
        row(3, 16'h123F, 6, 2, "R5");
        row(4, 16'h3000, 7, 7, "R5");
        row(5, 16'h3FFF, 7, 1, "R5");
        row(6, 16'h7FFF, 1, NM, "R5");
        chk(build_err == 1'b0, "R5", "no fault on shared keys", int'(build_err), 0);
    endtask

    // disjoint prefixes leave gaps
    task automatic t_gaps();
        new_build();
        send(16'h1000, 1'b0, 8'd1, 1'b0);
        send(16'h1FFF, 1'b1, 8'd1, 1'b0);
        send(16'h4000, 1'b0, 8'd2, 1'b0);
        send(16'h4FFF, 1'b1, 8'd2, 1'b1);
        settle();
        chk(cap_n == 4, "R7", "row count of new build", cap_n, 4);
        row(0, 16'h1000, 1, 1, "R7");
        row(1, 16'h1FFF, 1, NM, "R4");
        row(2, 16'h4000, 2, 2, "R4");
        row(3, 16'h4FFF, 2, NM, "R4");
    endtask

    // wrong closing identifier leaves the stack untouched
    task automatic t_mismatch();
        new_build();
        send(16'h1000, 1'b0, 8'd1, 1'b0);
        send(16'h2000, 1'b1, 8'd2, 1'b0);
        send(16'h3000, 1'b1, 8'd1, 1'b1);
        settle();
        chk(cap_gt[1] == 1, "R9", "gt after bad close", cap_gt[1], 1);
        chk(cap_gt[2] == NM, "R9", "gt after real close", cap_gt[2], NM);
        chk(build_err == 1'b1, "R9", "fault flagged", int'(build_err), 1);
    endtask

    // clean single full-length prefix; also proves the flag is cleared
    task automatic t_clean();
        chk(build_err == 1'b1, "R12", "flag held while idle", int'(build_err), 1);
        new_build();
        send(16'h5555, 1'b0, 8'd9, 1'b0);
        chk(build_err == 1'b0, "R12", "flag cleared at new build", int'(build_err), 0);
        send(16'h5555, 1'b1, 8'd9, 1'b1);
        settle();
        chk(cap_n == 1, "R5", "single full prefix rows", cap_n, 1);
        row(0, 16'h5555, 9, NM, "R5");
        chk(build_err == 1'b0, "R12", "clean build ends clear", int'(build_err), 0);
    endtask

    task automatic t_unclosed();
        new_build();
        send(16'h0100, 1'b0, 8'd1, 1'b0);
        send(16'h0200, 1'b0, 8'd2, 1'b1);
        chk(build_err == 1'b1, "R11", "open prefix at end", int'(build_err), 1);
        settle();
    endtask

    task automatic t_descend();
        new_build();
        send(16'h2000, 1'b0, 8'd1, 1'b0);
        chk(build_err == 1'b0, "R10", "no fault before descent", int'(build_err), 0);
        send(16'h1000, 1'b1, 8'd1, 1'b1);
        chk(build_err == 1'b1, "R10", "descending key", int'(build_err), 1);
        settle();
    endtask

    task automatic t_low_after_high();
        new_build();
        send(16'h1000, 1'b0, 8'd1, 1'b0);
        send(16'h2000, 1'b0, 8'd2, 1'b0);
        send(16'h2000, 1'b1, 8'd2, 1'b0);
        chk(build_err == 1'b0, "R10", "no fault before bad order", int'(build_err), 0);
        send(16'h2000, 1'b0, 8'd3, 1'b0);
        chk(build_err == 1'b1, "R10", "low after high at one key", int'(build_err), 1);
        send(16'h2000, 1'b1, 8'd3, 1'b0);
        send(16'h2FFF, 1'b1, 8'd1, 1'b1);
        settle();
    endtask

    // 18 nested lows exceed the 17-deep stack
    task automatic t_overflow();
        new_build();
        for (int i = 1; i <= 18; i++) begin
            send(16'(i * 16'h0100), 1'b0, 8'(i), 1'b0);
            if (i == 17) begin
                chk(build_err == 1'b0, "R8", "full stack no fault", int'(build_err), 0);
            end
        end
        chk(build_err == 1'b1, "R8", "push beyond depth", int'(build_err), 1);
        send(16'h2000, 1'b1, 8'd17, 1'b1);
        settle();
        chk(cap_gt[16] == 17, "R8", "gt at depth 17", cap_gt[16], 17);
        chk(cap_gt[17] == 17, "R8", "dropped push keeps top", cap_gt[17], 17);
        chk(cap_gt[18] == 16, "R8", "pop after overflow", cap_gt[18], 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_nested();
        t_merge();
        t_gaps();
        t_mismatch();
        t_clean();
        t_unclosed();
        t_clean();
        t_descend();
        t_clean();
        t_low_after_high();
        t_clean();
        t_overflow();
        t_clean();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule